// File: doc/BRIEF.md
# Reverse-Path Frame Queue with Vertical Parity Insertion

This block queues outgoing frames that software loads one 32-bit word at a time, and sends them out word by word on a reverse-path link. Software writes each frame complete: a base header, an extension header when the frame type carries one, the payload, padding up to a word boundary, and a final word whose low half is a parity placeholder. The block reads only the base header. From the frame type and the payload byte count it works out how many words the frame spans, so it knows which word carries the parity slot.

As each frame leaves, the block XORs its 16-bit half-words together. It puts the result into the low half of the final word in place of whatever software wrote there. A frame is normally held back until its last word is in the queue. The one exception is a queue that is full with no complete frame stored. In that case transmission is forced to start, which avoids a deadlock, and if the link later asks for a word that has not arrived yet, a sticky error is raised.

Top module: `rp_frame_tx`

## Requirements
- R1: Every word of a frame leaves in the order written, with its value unchanged. The one exception is the low 16 bits of the frame's final word.
- R2: The low 16 bits of a frame's final word leave as the XOR of all 16-bit half-words that come before them in the frame, including the upper half of that same final word. The placeholder value software wrote there has no effect.
- R3: Base header layout:
  - bits [31:28] hold the frame type;
  - bits [7:0] hold the payload byte count L;
  - the frame spans 1 + E + ceil(L/4) + 1 words, where E is 1 when an extension header is present and 0 otherwise;
  - tx_first marks the header word and tx_last marks the final word.
- R4: Type code 4'hC has no extension header (E=0). Every other type code has one (E=1).
- R5: No word of a frame is offered on the link until the frame's final word has been written. The single exception is the forced start described in R7.
- R6: wr_full is high while DEPTH words are stored. A write made while wr_full is high is dropped and has no effect on the words stored.
- R7: When the queue is full and holds no complete frame, the head frame is offered on the link (tx_valid and tx_first high) without waiting for its final word.
- R8: If tx_ready is high in the middle of a frame and no word is stored, tx_err rises on the next clock edge. It then stays high until reset.
- R9: After reset, tx_valid, wr_full and tx_err are low and the queue is empty.
- R10: A word is consumed when tx_valid and tx_ready are both high. While tx_ready is low, the offered word stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Frame word from software |
| wr_full | output | 1 | Queue full; writes are dropped |
| tx_ready | input | 1 | Link accepts the offered word |
| tx_valid | output | 1 | A word is offered |
| tx_data | output | 32 | Offered word, with parity in place on the final word |
| tx_first | output | 1 | Offered word is a base header |
| tx_last | output | 1 | Offered word is the final (parity) word |
| tx_err | output | 1 | Sticky underflow error |

## Verification
Two events can land on the same clock edge: a frame's final word arriving on the write side, and the link consuming the final word of the previous frame. Each one moves the count of ready frames in a different direction. The bench provokes this by writing a second frame while the first drains, timed so that the second frame's parity word lands on the edge where the first frame's last word leaves. It then judges the result by checking that the second frame is still offered and completes with correct parity. A forced start that runs into underflow is also exercised, and the rest of that frame is checked once its remaining words are written.

// File: rtl/rp_frame_pkg.sv
package rp_frame_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int KIND_W  = 4;
    localparam int LEN_W   = 8;
    localparam int MISC_W  = WORD_W - KIND_W - LEN_W;
    localparam int CNT_W   = LEN_W + 1;
    localparam logic [KIND_W-1:0] KIND_NOEXT = 4'hC;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CNT_W-1:0]  wcnt_t;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [MISC_W-1:0] misc;
        logic [LEN_W-1:0]  len;
    } base_hdr_t;

    typedef struct packed {
        logic  first;
        logic  last;
        word_t data;
    } tx_beat_t;

    function automatic logic carries_ext(word_t w);
        base_hdr_t h;
        h = base_hdr_t'(w);
        return h.kind != KIND_NOEXT;
    endfunction

    // total words: header + optional extension + padded payload + parity word
    function automatic wcnt_t span_words(word_t w);
        base_hdr_t h;
        wcnt_t     pay;
        h   = base_hdr_t'(w);
        pay = (wcnt_t'(h.len) + wcnt_t'(3)) >> 2;
        return pay + wcnt_t'(2) + (carries_ext(w) ? wcnt_t'(1) : wcnt_t'(0));
    endfunction

    function automatic half_t fold_halves(word_t w);
        return w[WORD_W-1:HALF_W] ^ w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/rp_word_store.sv
module rp_word_store
    import rp_frame_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t wdata,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full
);
    localparam int AW = $clog2(DEPTH);

    word_t         mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   fill_q;

    assign empty = (fill_q == '0);
    assign full  = (fill_q == (AW+1)'(DEPTH));
    assign head  = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            case ({push, pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/rp_write_tracker.sv
module rp_write_tracker
    import rp_frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t wdata,
    output logic  frame_done
);
    logic  busy_q;
    wcnt_t left_q;
    wcnt_t span_new;

    assign span_new   = span_words(wdata);
    assign frame_done = push && busy_q && (left_q == wcnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (push) begin
            if (!busy_q) begin
                busy_q <= 1'b1;
                left_q <= span_new - wcnt_t'(1);
            end else if (left_q == wcnt_t'(1)) begin
                busy_q <= 1'b0;
                left_q <= '0;
            end else begin
                left_q <= left_q - wcnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/rp_tx_engine.sv
module rp_tx_engine
    import rp_frame_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  word_t            head,
    input  logic             empty,
    input  logic             full,
    input  logic             frame_done,
    input  logic             tx_ready,
    output logic             pop,
    output logic             tx_valid,
    output tx_beat_t         beat,
    output logic             tx_err,
    output logic [$clog2(DEPTH+1)-1:0] frames_ready
);
    localparam int FR_W = $clog2(DEPTH+1);

    logic            in_frame_q;
    wcnt_t           left_q;
    half_t           acc_q;
    logic            err_q;
    logic [FR_W-1:0] frames_q;
    logic            may_start, at_last;

    assign may_start    = (frames_q != '0) || full;
    assign tx_valid     = !empty && (in_frame_q || may_start);
    assign at_last      = in_frame_q && (left_q == wcnt_t'(1));
    assign pop          = tx_valid && tx_ready;
    assign tx_err       = err_q;
    assign frames_ready = frames_q;

    always_comb begin
        beat.first = !in_frame_q;
        beat.last  = at_last;
        beat.data  = head;
        if (at_last)
            beat.data = {head[WORD_W-1:HALF_W], acc_q ^ head[WORD_W-1:HALF_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            left_q     <= '0;
            acc_q      <= '0;
        end else if (pop) begin
            if (!in_frame_q) begin
                in_frame_q <= 1'b1;
                left_q     <= span_words(head) - wcnt_t'(1);
                acc_q      <= fold_halves(head);
            end else if (at_last) begin
                in_frame_q <= 1'b0;
                left_q     <= '0;
                acc_q      <= '0;
            end else begin
                left_q     <= left_q - wcnt_t'(1);
                acc_q      <= acc_q ^ fold_halves(head);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frames_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case ({frame_done, pop && at_last})
                2'b10:   frames_q <= frames_q + 1'b1;
                2'b01:   frames_q <= frames_q - 1'b1;
                default: frames_q <= frames_q;
            endcase
            if (in_frame_q && empty && tx_ready) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rp_frame_tx.sv
module rp_frame_tx
    import rp_frame_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_full,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [31:0] tx_data,
    output logic        tx_first,
    output logic        tx_last,
    output logic        tx_err
);
    localparam int FR_W = $clog2(DEPTH+1);

    logic            push, pop, empty, full, frame_done;
    word_t           head;
    tx_beat_t        beat;
    logic [FR_W-1:0] frames_ready;

    assign push    = wr_valid && !full;
    assign wr_full = full;

    rp_word_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .push(push), .wdata(wr_data), .pop(pop),
        .head(head), .empty(empty), .full(full)
    );

    rp_write_tracker track_i (
        .clk(clk), .rst(rst), .push(push), .wdata(wr_data), .frame_done(frame_done)
    );

    rp_tx_engine #(.DEPTH(DEPTH)) eng_i (
        .clk(clk), .rst(rst), .head(head), .empty(empty), .full(full),
        .frame_done(frame_done), .tx_ready(tx_ready), .pop(pop),
        .tx_valid(tx_valid), .beat(beat), .tx_err(tx_err),
        .frames_ready(frames_ready)
    );

    assign tx_data  = beat.data;
    assign tx_first = beat.first;
    assign tx_last  = beat.last;
endmodule

// File: rtl/rp_frame_tx_chk.sv
module rp_frame_tx_chk #(
    parameter int FR_W = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_full,
    input logic            tx_ready,
    input logic            tx_valid,
    input logic [31:0]     tx_data,
    input logic            tx_first,
    input logic            tx_last,
    input logic            tx_err,
    input logic [FR_W-1:0] frames_ready
);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        tx_err |=> tx_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_err) |-> $past(tx_ready && !tx_valid));

    p_hold_offer_r10: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_full_stays_r6: assert property (@(posedge clk) disable iff (rst)
        wr_full && !(tx_valid && tx_ready) |=> wr_full);

    p_start_gate_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_first |-> (frames_ready != '0) || wr_full);

    p_next_is_header_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_last |=> !tx_valid || tx_first);

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(tx_first && tx_last));
endmodule

bind rp_frame_tx rp_frame_tx_chk #(.FR_W(FR_W)) chk_i (
    .clk(clk), .rst(rst), .wr_full(wr_full), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last), .tx_err(tx_err), .frames_ready(frames_ready)
);

// File: tb/rp_frame_tx_tb.sv
module rp_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int NVEC       = 8;
    // each vector: [31:28] type, [27:20] payload bytes, [19:0] seed
    localparam logic [31:0] VECS [NVEC] = '{
        {4'hC, 8'd0,  20'h00011}, {4'hC, 8'd1,  20'h12345},
        {4'hC, 8'd4,  20'hABCDE}, {4'h1, 8'd3,  20'h0F0F0},
        {4'h2, 8'd8,  20'h55555}, {4'h0, 8'd5,  20'h9A9A9},
        {4'hF, 8'd48, 20'h31415}, {4'hC, 8'd52, 20'h27182}
    };

    logic clk = 0, rst = 1;
    logic wr_valid = 0, tx_ready = 0;
    logic [31:0] wr_data = '0;
    logic wr_full, tx_valid, tx_first, tx_last, tx_err;
    logic [31:0] tx_data;

    int errors = 0, checks = 0;
    logic [31:0] wr_list [256];
    logic [31:0] exp_list [256];
    logic        exp_first [256];
    logic        exp_last [256];
    int n_wr = 0, n_exp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_frame_tx #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_full(wr_full), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last), .tx_err(tx_err)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // builds a frame into the write list and the expected list
    task automatic build(input logic [3:0] typ, input logic [7:0] len, input logic [19:0] seed);
        int nw;
        logic [15:0] par;
        logic [31:0] w;
        nw  = 2 + ((typ != 4'hC) ? 1 : 0) + (int'(len) + 3) / 4;
        par = '0;
        for (int i = 0; i < nw; i++) begin
            if (i == 0) w = {typ, seed, len};
            else        w = {seed[11:0], 20'h0} ^ (32'h9E3779B9 * (i + 7)) ^ {12'h0, seed};
            exp_first[n_exp] = (i == 0);
            exp_last[n_exp]  = (i == nw - 1);
            if (i == nw - 1) begin
                wr_list[n_wr] = {w[31:16], 16'hDEAD};
                par = par ^ w[31:16];
                exp_list[n_exp] = {w[31:16], par};
            end else begin
                wr_list[n_wr] = w;
                par = par ^ w[31:16] ^ w[15:0];
                exp_list[n_exp] = w;
            end
            n_wr++;
            n_exp++;
        end
    endtask

    task automatic send(input int start, input int n);
        for (int i = start; i < start + n; i++) begin
            @(negedge clk);
            while (wr_full) @(negedge clk);
            wr_valid = 1;
            wr_data  = wr_list[i];
        end
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic recv(input int start, input int n);
        int idx;
        idx = start;
        while (idx < start + n) begin
            @(negedge clk);
            tx_ready = 1;
            #1;
            if (tx_valid) begin
                check(tx_data == exp_list[idx], exp_last[idx] ? "R2 parity word" : "R1 word", tx_data, exp_list[idx]);
                check(tx_first == exp_first[idx] && tx_last == exp_last[idx], "R3/R4 frame markers",
                      {30'h0, tx_first, tx_last}, {30'h0, exp_first[idx], exp_last[idx]});
                idx++;
            end
        end
        @(posedge clk);
        #1 tx_ready = 0;
    endtask

    task automatic do_reset();
        rst = 1; wr_valid = 0; tx_ready = 0;
        n_wr = 0; n_exp = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(!tx_valid && !wr_full && !tx_err, "R9 reset state", {29'h0, tx_valid, wr_full, tx_err}, 32'h0);

        // vector table: each frame written then drained
        for (int v = 0; v < NVEC; v++) begin
            n_wr = 0; n_exp = 0;
            build(VECS[v][31:28], VECS[v][27:20], VECS[v][19:0]);
            send(0, n_wr);
            recv(0, n_exp);
        end

        // R5: frame held until its final word is written
        do_reset();
        build(4'h1, 8'd8, 20'h77777);
        send(0, n_wr - 1);
        begin
            logic seen;
            seen = 0;
            tx_ready = 1;
            repeat (6) begin
                @(negedge clk);
                #1 seen = seen | tx_valid;
            end
            tx_ready = 0;
            check(!seen, "R5 held before final word", {31'h0, seen}, 32'h0);
        end
        send(n_wr - 1, 1);
        recv(0, n_exp);

        // R6: fill completely, extra write dropped
        do_reset();
        for (int k = 0; k < 4; k++) build(4'hC, 8'd4, 20'h100 + k);
        build(4'hC, 8'd8, 20'h200);
        send(0, n_wr);
        @(negedge clk);
        check(wr_full, "R6 full at DEPTH", {31'h0, wr_full}, 32'h1);
        wr_valid = 1; wr_data = 32'h1FFF_FFFF;
        repeat (2) @(negedge clk);
        wr_valid = 0;
        recv(0, n_exp);
        @(negedge clk);
        check(!tx_valid, "R6 dropped word not offered", {31'h0, tx_valid}, 32'h0);
        begin
            int s;
            s = n_wr;
            build(4'h3, 8'd6, 20'h44444);
            send(s, n_wr - s);
            recv(s, n_exp - s);
        end

        // same-cycle: parity of B written while A's last word leaves
        do_reset();
        build(4'h1, 8'd8, 20'h0A0A0);
        build(4'h2, 8'd8, 20'h0B0B0);
        send(0, 5);
        fork
            send(5, 5);
            recv(0, 10);
        join

        // R7/R8: oversize frame forces start, then underflows
        do_reset();
        build(4'h1, 8'd80, 20'h5EED5);
        send(0, DEPTH);
        @(negedge clk);
        check(tx_valid && tx_first, "R7 forced start when full", {30'h0, tx_valid, tx_first}, 32'h3);
        check(!tx_err, "R8 no error before underflow", {31'h0, tx_err}, 32'h0);
        recv(0, DEPTH);
        @(negedge clk);
        tx_ready = 1;
        @(posedge clk);
        #1 tx_ready = 0;
        check(tx_err, "R8 underflow flagged", {31'h0, tx_err}, 32'h1);
        fork
            send(DEPTH, n_wr - DEPTH);
            recv(DEPTH, n_exp - DEPTH);
        join
        @(negedge clk);
        check(tx_err, "R8 error sticky", {31'h0, tx_err}, 32'h1);
        do_reset();
        @(negedge clk);
        check(!tx_err, "R9 reset clears error", {31'h0, tx_err}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule